// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the command pins of a 16-bit single-data-rate SDRAM (four internal banks, 12 row bits, 8 column bits) from reset onward. Once reset is released it raises clock enable and holds NOP for a stabilisation delay. It then closes every bank with one precharge and runs a burst of auto-refresh commands. Next it programs the mode register with burst length 2, sequential bursts, CAS latency 3 and writes that touch a single location. It then waits out the mode-register delay before it declares the memory ready.

From then on a free-running interval counter requests periodic refresh. Each request is served in the next idle cycle as a precharge-all followed by one auto-refresh. Every timing gap is a parameter counted in controller clocks. The refresh reload comes from the clock rate and the refresh interval, less a safety margin. The busy output marks each command and the gap that follows it, so a neighbouring datapath knows when the pins are taken.

Top module: `sdram_boot_refresh`

## Requirements
- R1: While reset is asserted, sd_cke is 0, sd_cs_n, sd_ras_n, sd_cas_n and sd_we_n are all 1, sd_ba and sd_addr are 0, and ready and busy are 0. Whenever sd_cke is 0 the four command pins are 1.
- R2: Call the state after the first rising edge with reset released cycle 0. For cycles 0 to STAB_CYCLES-1, sd_cke is 1 and the pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111). sd_cke never falls again before reset.
- R3: In cycle STAB_CYCLES the block drives precharge-all: pins 0010 with sd_addr[10] = 1.
- R4: AREF_REPEAT+1 auto-refresh commands (pins 0001) follow. The first comes T_RP cycles after the precharge, and each later one T_RC cycles after the one before.
- R5: T_RC cycles after the last initial auto-refresh, the block drives load-mode (pins 0000) with sd_ba = 0 and sd_addr = 0x231: bits 2:0 = 001 (burst 2), bit 3 = 0 (sequential), bits 6:4 = 011 (CAS 3), bits 8:7 = 00, bit 9 = 1 (single-location writes).
- R6: ready rises exactly T_MRD cycles after load-mode. It stays high until reset, and no load-mode is issued once ready is high.
- R7: Every command lasts one cycle, and NOP (0111) is driven in every cycle between commands.
- R8: busy is 1 from each command's cycle up to the cycle before the next step starts. It is 0 during the stabilisation wait and while idle.
- R9: The refresh reload R is round(CLK_KHZ*REFRESH_NS/10^6) - REFRESH_MARGIN. The defaults of 90000 kHz, 7810 ns and 20 give 683.
- R10: Let I be the first cycle with ready high. For each m >= 1, a precharge-all is issued in cycle I + m*(R+1) + 1. A single auto-refresh follows T_RP cycles later, and the block is idle again T_RC cycles after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_BITS | Bank address |
| sd_addr | output | ROW_BITS | Address bus, also carries the mode word |
| ready | output | 1 | Initialisation complete |
| busy | output | 1 | A command or its gap occupies the pins |

## Verification
The pins come straight from the registered sequencer state through combinational decoding, so any effect is visible one edge after the state change. The bench computes the expected command, busy and ready for cycle k arithmetically from the parameters: the precharge at STAB_CYCLES, the refreshes at offsets of T_RP plus multiples of T_RC, load-mode after them, ready T_MRD later, and the refresh period R+1 with service one cycle after the request. It samples every cycle on the falling edge after edge k and compares. Two configurations run side by side: a short one with unequal gaps and two extra refreshes, and the default one, which also pins down the reload of 683.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF, ST_STAB, ST_PRE, ST_AREF, ST_LMR, ST_WAIT, ST_IDLE
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_INHIBIT, CMD_NOP, CMD_PRECHARGE, CMD_REFRESH, CMD_LOADMODE
    } sdr_cmd_t;

    // Mode word layout: [2:0] burst length code, [3] burst type,
    // [6:4] CAS latency, [8:7] operating mode, [9] write burst mode.
    function automatic logic [11:0] mode_word(input logic [2:0] bl_code,
                                              input logic       interleave,
                                              input logic [2:0] cas,
                                              input logic       single_wr);
        logic [11:0] w;
        w      = '0;
        w[2:0] = bl_code;
        w[3]   = interleave;
        w[6:4] = cas;
        w[9]   = single_wr;
        return w;
    endfunction

endpackage

// File: rtl/sdr_countdown.sv
module sdr_countdown #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)            cnt_d = load_val;
        else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int unsigned W      = 10,
    parameter int unsigned RELOAD = 683
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam logic [W-1:0] RELOAD_V = W'(RELOAD);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || cnt_q == '0) cnt_d = RELOAD_V;
        else                     cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RELOAD_V;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/sdr_cmd_encode.sv
module sdr_cmd_encode
    import sdr_seq_pkg::*;
#(
    parameter int unsigned ROW_BITS  = 12,
    parameter int unsigned BANK_BITS = 2,
    parameter logic [11:0] MODE_WORD = 12'h231
) (
    input  sdr_cmd_t              cmd,
    output logic                  cke,
    output logic                  cs_n,
    output logic                  ras_n,
    output logic                  cas_n,
    output logic                  we_n,
    output logic [BANK_BITS-1:0]  ba,
    output logic [ROW_BITS-1:0]   addr
);
    // Address bit 10 selects all banks for a precharge.
    localparam logic [ROW_BITS-1:0] PRE_ALL = ROW_BITS'(1) << 10;
    localparam logic [ROW_BITS-1:0] MODE_V  = ROW_BITS'(MODE_WORD);

    always_comb begin
        cke  = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        ba   = '0;
        addr = '0;
        unique case (cmd)
            CMD_INHIBIT: begin
                cke = 1'b0;
                {cs_n, ras_n, cas_n, we_n} = 4'b1111;
            end
            CMD_PRECHARGE: begin
                {cs_n, ras_n, cas_n, we_n} = 4'b0010;
                addr = PRE_ALL;
            end
            CMD_REFRESH:  {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            CMD_LOADMODE: begin
                {cs_n, ras_n, cas_n, we_n} = 4'b0000;
                addr = MODE_V;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sdram_boot_refresh.sv
module sdram_boot_refresh
    import sdr_seq_pkg::*;
#(
    parameter int unsigned CLK_KHZ        = 90000,
    parameter int unsigned REFRESH_NS     = 7810,
    parameter int unsigned REFRESH_MARGIN = 20,
    parameter int unsigned STAB_CYCLES    = 9000,
    parameter int unsigned T_RP           = 2,
    parameter int unsigned T_RC           = 7,
    parameter int unsigned T_MRD          = 2,
    parameter int unsigned AREF_REPEAT    = 3,
    parameter int unsigned ROW_BITS       = 12,
    parameter int unsigned BANK_BITS      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 sd_cke,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [BANK_BITS-1:0] sd_ba,
    output logic [ROW_BITS-1:0]  sd_addr,
    output logic                 ready,
    output logic                 busy
);
    // Refresh reload: rounded clocks per interval less a margin.
    localparam longint unsigned REF_PRODUCT =
        longint'(CLK_KHZ) * longint'(REFRESH_NS);
    localparam int unsigned REF_RELOAD =
        int'((REF_PRODUCT + 64'd500000) / 64'd1000000) - REFRESH_MARGIN;
    localparam int unsigned REF_W = $clog2(REF_RELOAD + 1);

    localparam int unsigned GAP_MAX1 = (T_RC > T_RP) ? T_RC : T_RP;
    localparam int unsigned GAP_MAX2 = (GAP_MAX1 > T_MRD) ? GAP_MAX1 : T_MRD;
    localparam int unsigned WAIT_MAX = (STAB_CYCLES > GAP_MAX2) ? STAB_CYCLES : GAP_MAX2;
    localparam int unsigned WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam int unsigned AREF_W   = $clog2(AREF_REPEAT + 2);

    // A gap of T cycles is one command cycle plus T-1 NOP cycles; gaps below 2 clamp to 2.
    localparam logic [WAIT_W-1:0] STAB_LOAD = WAIT_W'(STAB_CYCLES - 1);
    localparam logic [WAIT_W-1:0] RP_GAP    = WAIT_W'((T_RP  < 2) ? 0 : T_RP  - 2);
    localparam logic [WAIT_W-1:0] RC_GAP    = WAIT_W'((T_RC  < 2) ? 0 : T_RC  - 2);
    localparam logic [WAIT_W-1:0] MRD_GAP   = WAIT_W'((T_MRD < 2) ? 0 : T_MRD - 2);

    localparam logic [11:0] MODE_WORD = mode_word(3'b001, 1'b0, 3'd3, 1'b1);

    typedef struct packed {
        seq_state_t         state;
        seq_state_t         after;
        logic [AREF_W-1:0]  aref_left;
        logic               ready;
        logic               pending;
    } ctl_t;

    ctl_t              c_q, c_d;
    sdr_cmd_t          cmd;
    logic              busy_c;
    logic              wt_load;
    logic [WAIT_W-1:0] wt_val;
    logic              wt_zero;
    logic              ref_tick;

    sdr_countdown #(.W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wt_load),
        .load_val (wt_val),
        .zero     (wt_zero)
    );

    sdr_refresh_timer #(.W(REF_W), .RELOAD(REF_RELOAD)) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (c_q.ready),
        .tick  (ref_tick)
    );

    always_comb begin
        c_d       = c_q;
        cmd       = CMD_NOP;
        busy_c    = 1'b0;
        wt_load   = 1'b0;
        wt_val    = '0;
        c_d.pending = c_q.pending | ref_tick;
        unique case (c_q.state)
            ST_OFF: begin
                cmd       = CMD_INHIBIT;
                wt_load   = 1'b1;
                wt_val    = STAB_LOAD;
                c_d.state = ST_STAB;
            end
            ST_STAB: if (wt_zero) c_d.state = ST_PRE;
            ST_PRE: begin
                cmd       = CMD_PRECHARGE;
                busy_c    = 1'b1;
                wt_load   = 1'b1;
                wt_val    = RP_GAP;
                c_d.state = ST_WAIT;
                c_d.after = ST_AREF;
            end
            ST_AREF: begin
                cmd       = CMD_REFRESH;
                busy_c    = 1'b1;
                wt_load   = 1'b1;
                wt_val    = RC_GAP;
                c_d.state = ST_WAIT;
                if (c_q.aref_left != '0) begin
                    c_d.after     = ST_AREF;
                    c_d.aref_left = c_q.aref_left - 1'b1;
                end else begin
                    c_d.after = c_q.ready ? ST_IDLE : ST_LMR;
                end
            end
            ST_LMR: begin
                cmd       = CMD_LOADMODE;
                busy_c    = 1'b1;
                wt_load   = 1'b1;
                wt_val    = MRD_GAP;
                c_d.state = ST_WAIT;
                c_d.after = ST_IDLE;
            end
            ST_WAIT: begin
                busy_c = 1'b1;
                if (wt_zero) begin
                    c_d.state = c_q.after;
                    if (c_q.after == ST_IDLE) c_d.ready = 1'b1;
                end
            end
            ST_IDLE: if (c_q.pending) begin
                c_d.pending   = ref_tick;
                c_d.state     = ST_PRE;
                c_d.aref_left = '0;
            end
            default: c_d.state = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state     <= ST_OFF;
            c_q.after     <= ST_OFF;
            c_q.aref_left <= AREF_W'(AREF_REPEAT);
            c_q.ready     <= 1'b0;
            c_q.pending   <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    sdr_cmd_encode #(
        .ROW_BITS  (ROW_BITS),
        .BANK_BITS (BANK_BITS),
        .MODE_WORD (MODE_WORD)
    ) u_enc (
        .cmd   (cmd),
        .cke   (sd_cke),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n),
        .ba    (sd_ba),
        .addr  (sd_addr)
    );

    assign ready = c_q.ready;
    assign busy  = busy_c;
endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic ready,
    input logic busy
);
    logic is_cmd, is_lmr;
    assign is_cmd = !cs_n && !(ras_n && cas_n && we_n);
    assign is_lmr = !cs_n && !ras_n && !cas_n && !we_n;

    assert_pins_inactive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (cs_n && ras_n && cas_n && we_n));

    assert_cke_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    assert_one_cycle_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |=> !is_cmd);

    assert_cmd_marks_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |-> busy);

    assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    assert_no_mode_after_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !is_lmr);
endmodule

bind sdram_boot_refresh sdr_seq_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cke   (sd_cke),
    .cs_n  (sd_cs_n),
    .ras_n (sd_ras_n),
    .cas_n (sd_cas_n),
    .we_n  (sd_we_n),
    .ready (ready),
    .busy  (busy)
);

// File: tb/sim_sdram_boot_refresh.sv
module sim_sdram_boot_refresh;
    // Short configuration for u0
    localparam int S0 = 12, RP0 = 3, RC0 = 5, MRD0 = 2, N0 = 2, R0 = 30;
    // Default configuration for u1
    localparam int S1 = 9000, RP1 = 2, RC1 = 7, MRD1 = 2, N1 = 3, R1V = 683;
    localparam int K_END = 10450;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int total = 0;
    int bad   = 0;

    logic        cke0, cs0, ras0, cas0, we0, rdy0, bsy0;
    logic [1:0]  ba0;
    logic [11:0] ad0;
    logic        cke1, cs1, ras1, cas1, we1, rdy1, bsy1;
    logic [1:0]  ba1;
    logic [11:0] ad1;

    sdram_boot_refresh #(
        .CLK_KHZ(10000), .REFRESH_NS(5000), .REFRESH_MARGIN(20),
        .STAB_CYCLES(S0), .T_RP(RP0), .T_RC(RC0), .T_MRD(MRD0), .AREF_REPEAT(N0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sd_cke(cke0), .sd_cs_n(cs0), .sd_ras_n(ras0),
        .sd_cas_n(cas0), .sd_we_n(we0), .sd_ba(ba0), .sd_addr(ad0),
        .ready(rdy0), .busy(bsy0)
    );

    sdram_boot_refresh u1 (
        .clk(clk), .rst_n(rst_n), .sd_cke(cke1), .sd_cs_n(cs1), .sd_ras_n(ras1),
        .sd_cas_n(cas1), .sd_we_n(we1), .sd_ba(ba1), .sd_addr(ad1),
        .ready(rdy1), .busy(bsy1)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // 0 idle NOP, 1 NOP in a gap, 2 precharge, 3 refresh, 4 load mode
    function automatic int exp_phase(int k, int s, int rp, int rc, int mrd, int n, int r);
        int a, m, i, d, e;
        if (k < s) return 0;
        if (k == s) return 2;
        if (k < s + rp) return 1;
        for (int j = 0; j <= n; j++) begin
            a = s + rp + j * rc;
            if (k == a) return 3;
            if (k < a + rc) return 1;
        end
        m = s + rp + (n + 1) * rc;
        if (k == m) return 4;
        if (k < m + mrd) return 1;
        i = m + mrd;
        d = k - i;
        if (d < r + 2) return 0;
        e = (d - (r + 2)) % (r + 1);
        if (e == 0) return 2;
        if (e < rp) return 1;
        if (e == rp) return 3;
        if (e < rp + rc) return 1;
        return 0;
    endfunction

    function automatic int decode(logic cke, logic cs, logic ras, logic cas, logic we);
        if (!cke) return 6;
        case ({cs, ras, cas, we})
            4'b0111: return 0;
            4'b0010: return 2;
            4'b0001: return 3;
            4'b0000: return 4;
            default: return 7;
        endcase
    endfunction

    task automatic check_cycle(input string nm, input int k,
                               input logic cke, input logic cs, input logic ras,
                               input logic cas, input logic we, input logic [1:0] ba,
                               input logic [11:0] ad, input logic rdy, input logic bsy,
                               input int s, input int rp, input int rc, input int mrd,
                               input int n, input int r);
        int ph, expc, act, i;
        string req;
        ph   = exp_phase(k, s, rp, rc, mrd, n, r);
        i    = s + rp + (n + 1) * rc + mrd;
        expc = (ph <= 1) ? 0 : ph;
        act  = decode(cke, cs, ras, cas, we);
        if (k < s)                         req = "R2";
        else if (k >= i && nm == "u1")     req = "R9";
        else if (k >= i)                   req = "R10";
        else if (ph == 2)                  req = "R3";
        else if (ph == 3)                  req = "R4";
        else if (ph == 4)                  req = "R5";
        else                               req = "R7";
        check(act == expc, req, {nm, " command"}, act, expc);
        check(bsy == (ph != 0), "R8", {nm, " busy"}, int'(bsy), int'(ph != 0));
        check(rdy == (k >= i), "R6", {nm, " ready"}, int'(rdy), int'(k >= i));
        if (ph == 2)
            check(ad[10] == 1'b1, "R3", {nm, " precharge A10"}, int'(ad[10]), 1);
        if (ph == 4)
            check({ba, ad} == {2'b00, 12'h231}, "R5", {nm, " mode word"},
                  int'({ba, ad}), 'h231);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state of both instances
        check({cke0, cs0, ras0, cas0, we0, ba0, ad0, rdy0, bsy0} ==
              {1'b0, 4'hF, 2'b00, 12'h000, 2'b00}, "R1", "u0 reset pins",
              int'({cke0, cs0, ras0, cas0, we0}), 'hF);
        check({cke1, cs1, ras1, cas1, we1, ba1, ad1, rdy1, bsy1} ==
              {1'b0, 4'hF, 2'b00, 12'h000, 2'b00}, "R1", "u1 reset pins",
              int'({cke1, cs1, ras1, cas1, we1}), 'hF);
        rst_n = 1'b1;
        for (int k = 0; k < K_END; k++) begin
            @(posedge clk);
            @(negedge clk);
            check_cycle("u0", k, cke0, cs0, ras0, cas0, we0, ba0, ad0, rdy0, bsy0,
                        S0, RP0, RC0, MRD0, N0, R0);
            check_cycle("u1", k, cke1, cs1, ras1, cas1, we1, ba1, ad1, rdy1, bsy1,
                        S1, RP1, RC1, MRD1, N1, R1V);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, K_END);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule